// File: doc/BRIEF.md
# Single-Cycle RV32 Integer Core

This block is a compact 32-bit RISC-V integer core that completes one instruction per clock: it fetches, decodes, reads two registers, computes, touches data memory and writes back, all in the same cycle. It supports the register and immediate forms of add, subtract, and, or and xor, the four branches BEQ, BNE, BLT and BGE, and word loads and stores. Instruction and data storage are small internal arrays that are read combinationally. The program is written into instruction storage through a preload port, usually while reset is held.

Retirement is visible at the ports. The current PC is shown, and a writeback trace (valid, destination register, value) is driven in the same cycle as the register write it describes. A sticky pass flag rises once register x10 receives the value 45. That is the result of the built-in test program, which sums 1 through 9.

Reset is asynchronous and active low. The reset input is expected to be deasserted in step with the clock. The core holds its PC at 0 for one cycle after release, so the first instruction that retires comes from address 0.

Top module: `mrv_core`

## Requirements
- R1: While rst_n is low, and during the first cycle after its release, pc_o is 0 and wb_valid_o and pass_o are 0. The instruction at address 0 retires in the second cycle after release.
- R2: A non-branch instruction, or a branch whose condition is false, advances pc_o by 4 in the next cycle.
- R3: Branches use opcode 1100011, with funct3 000=BEQ, 001=BNE, 100=BLT and 101=BGE. BLT and BGE compare as signed values. When the condition holds, the next pc_o is pc_o plus the sign-extended B-format immediate; an offset of 0 holds the PC in place.
- R4: Register arithmetic uses opcode 0110011, with funct3 000 = add, or subtract (rs1 minus rs2) when instruction bit 30 is set, 100 = xor, 110 = or and 111 = and. Both source registers are read in the same cycle.
- R5: Immediate arithmetic uses opcode 0010011, with funct3 000 = add, 100 = xor, 110 = or and 111 = and. The second operand is the sign-extended 12-bit I immediate.
- R6: Register x0 reads as zero. A write that targets it changes nothing and shows no trace.
- R7: LW (opcode 0000011, funct3 010) and SW (opcode 0100011, funct3 010) address memory at rs1 plus the sign-extended immediate. The word index is address bits [6:2], so addresses that differ only above bit 6 alias. A store takes effect at the clock edge that ends its cycle, and a store produces no trace.
- R8: wb_valid_o is high exactly in the cycle an instruction writes a nonzero rd, with wb_rd_o and wb_data_o showing that write. An instruction whose source is also its destination reads the old value.
- R9: pass_o rises in the cycle after x10 is written with 45 and stays high until reset. The preloaded sum loop raises it within 40 cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_we | input | 1 | Preload write strobe for instruction storage |
| imem_waddr | input | 5 | Preload word index |
| imem_wdata | input | 32 | Preload instruction word |
| pc_o | output | 32 | Address of the instruction in the current cycle |
| wb_valid_o | output | 1 | A register write happens this cycle |
| wb_rd_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |
| pass_o | output | 1 | Sticky flag: x10 received 45 |

## Verification
Two things can happen in one cycle: a register is read as an operand, and the same register is written by that same instruction. The case is provoked with an add whose destination is also both of its sources. The bench expects the trace to show double the old value, and the next instruction to see the new one. A second pairing is a store followed at once by a load from an aliased address, which tests that the store's edge write is visible in the very next cycle. Branch outcomes are judged from the sequence of pc_o values alone.

// File: rtl/mrv_pkg.sv
package mrv_pkg;

  localparam int XLEN  = 32;
  localparam int RIDX_W = 5;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_XOR
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_NONE,
    WB_ALU,
    WB_MEM
  } wb_sel_e;

  typedef enum logic [2:0] {
    BR_NONE,
    BR_EQ,
    BR_NE,
    BR_LT,
    BR_GE
  } br_kind_e;

  typedef struct packed {
    logic [RIDX_W-1:0] rs1;
    logic [RIDX_W-1:0] rs2;
    logic [RIDX_W-1:0] rd;
    logic [XLEN-1:0]   imm;
    logic              use_imm;
    alu_op_e           op;
    wb_sel_e           wb;
    br_kind_e          br;
    logic              mem_wr;
  } dec_t;

endpackage

// File: rtl/mrv_decode.sv
module mrv_decode
  import mrv_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);

  logic [6:0]      opc;
  logic [2:0]      f3;
  logic [XLEN-1:0] imm_i;
  logic [XLEN-1:0] imm_s;
  logic [XLEN-1:0] imm_b;

  assign opc   = instr[6:0];
  assign f3    = instr[14:12];
  assign imm_i = {{(XLEN-12){instr[31]}}, instr[31:20]};
  assign imm_s = {{(XLEN-12){instr[31]}}, instr[31:25], instr[11:7]};
  assign imm_b = {{(XLEN-13){instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};

  always_comb begin
    dec         = '0;
    dec.rs1     = instr[19:15];
    dec.rs2     = instr[24:20];
    dec.rd      = instr[11:7];
    dec.op      = ALU_ADD;
    dec.wb      = WB_NONE;
    dec.br      = BR_NONE;
    dec.use_imm = 1'b0;
    dec.mem_wr  = 1'b0;
    dec.imm     = imm_i;
    unique case (opc)
      OPC_REG: begin
        dec.wb = WB_ALU;
        unique case (f3)
          3'b000:  dec.op = instr[30] ? ALU_SUB : ALU_ADD;
          3'b100:  dec.op = ALU_XOR;
          3'b110:  dec.op = ALU_OR;
          3'b111:  dec.op = ALU_AND;
          default: dec.wb = WB_NONE;
        endcase
      end
      OPC_IMM: begin
        dec.wb      = WB_ALU;
        dec.use_imm = 1'b1;
        unique case (f3)
          3'b000:  dec.op = ALU_ADD;
          3'b100:  dec.op = ALU_XOR;
          3'b110:  dec.op = ALU_OR;
          3'b111:  dec.op = ALU_AND;
          default: dec.wb = WB_NONE;
        endcase
      end
      OPC_LOAD: begin
        dec.use_imm = 1'b1;
        if (f3 == 3'b010) dec.wb = WB_MEM;
      end
      OPC_STORE: begin
        dec.use_imm = 1'b1;
        dec.imm     = imm_s;
        dec.mem_wr  = (f3 == 3'b010);
      end
      OPC_BRANCH: begin
        dec.imm = imm_b;
        unique case (f3)
          3'b000:  dec.br = BR_EQ;
          3'b001:  dec.br = BR_NE;
          3'b100:  dec.br = BR_LT;
          3'b101:  dec.br = BR_GE;
          default: dec.br = BR_NONE;
        endcase
      end
      default: begin
        dec.wb = WB_NONE;
      end
    endcase
  end

endmodule

// File: rtl/mrv_regfile.sv
module mrv_regfile #(
  parameter int NREG   = 32,
  parameter int NRD    = 2,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       we,
  input  logic [AW-1:0]              wa,
  input  logic [DATA_W-1:0]          wd,
  input  logic [NRD-1:0][AW-1:0]     ra,
  output logic [NRD-1:0][DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] regs [NREG];
  logic              wr_en;

  // entry 0 is never written; the read ports return zero for it
  assign wr_en = we && (wa != '0);

  always_ff @(posedge clk) begin
    if (wr_en) begin
      regs[wa] <= wd;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = (ra[p] == '0) ? '0 : regs[ra[p]];
  end

endmodule

// File: rtl/mrv_alu.sv
module mrv_alu
  import mrv_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  input  logic [XLEN-1:0] cmp_b,
  output logic [XLEN-1:0] y,
  output logic            eq,
  output logic            lt
);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      default: y = a + b;
    endcase
  end

  assign eq = (a == cmp_b);
  assign lt = ($signed(a) < $signed(cmp_b));

endmodule

// File: rtl/mrv_core.sv
module mrv_core
  import mrv_pkg::*;
#(
  parameter int IMEM_WORDS = 32,
  parameter int DMEM_WORDS = 32,
  parameter int NREG       = 32,
  parameter int PASS_REG   = 10,
  parameter int PASS_VALUE = 45,
  localparam int IA_W      = $clog2(IMEM_WORDS),
  localparam int DA_W      = $clog2(DMEM_WORDS),
  localparam int RA_W      = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             imem_we,
  input  logic [IA_W-1:0]  imem_waddr,
  input  logic [XLEN-1:0]  imem_wdata,
  output logic [XLEN-1:0]  pc_o,
  output logic             wb_valid_o,
  output logic [RA_W-1:0]  wb_rd_o,
  output logic [XLEN-1:0]  wb_data_o,
  output logic             pass_o
);

  // state
  logic            run_q, run_d;
  logic [XLEN-1:0] pc_q, pc_d;
  logic            pass_q, pass_d;

  // storage
  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  // datapath
  logic [XLEN-1:0]                instr;
  dec_t                           dec;
  logic [1:0][RA_W-1:0]           rf_ra;
  logic [1:0][XLEN-1:0]           rf_rdata;
  logic [XLEN-1:0]                rs1_v, rs2_v, opb, alu_y;
  logic                           cmp_eq, cmp_lt;
  logic                           br_taken;
  logic [DA_W-1:0]                d_idx;
  logic [XLEN-1:0]                d_rdata;
  logic                           dmem_we;
  logic                           wb_en;
  logic [XLEN-1:0]                wb_data;

  // fetch
  always_ff @(posedge clk) begin
    if (imem_we) begin
      imem[imem_waddr] <= imem_wdata;
    end
  end

  assign instr = imem[pc_q[IA_W+1:2]];

  // decode
  mrv_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  // register read
  assign rf_ra[0] = dec.rs1;
  assign rf_ra[1] = dec.rs2;

  mrv_regfile #(
    .NREG   (NREG),
    .NRD    (2),
    .DATA_W (XLEN)
  ) u_rf (
    .clk   (clk),
    .we    (wb_en),
    .wa    (dec.rd),
    .wd    (wb_data),
    .ra    (rf_ra),
    .rdata (rf_rdata)
  );

  assign rs1_v = rf_rdata[0];
  assign rs2_v = rf_rdata[1];
  assign opb   = dec.use_imm ? dec.imm : rs2_v;

  // execute; the same adder forms load and store addresses
  mrv_alu u_alu (
    .a     (rs1_v),
    .b     (opb),
    .op    (dec.op),
    .cmp_b (rs2_v),
    .y     (alu_y),
    .eq    (cmp_eq),
    .lt    (cmp_lt)
  );

  always_comb begin
    unique case (dec.br)
      BR_EQ:   br_taken = cmp_eq;
      BR_NE:   br_taken = !cmp_eq;
      BR_LT:   br_taken = cmp_lt;
      BR_GE:   br_taken = !cmp_lt;
      default: br_taken = 1'b0;
    endcase
  end

  // memory
  assign d_idx   = alu_y[DA_W+1:2];
  assign d_rdata = dmem[d_idx];
  assign dmem_we = run_q && dec.mem_wr;

  always_ff @(posedge clk) begin
    if (dmem_we) begin
      dmem[d_idx] <= rs2_v;
    end
  end

  // writeback
  assign wb_data = (dec.wb == WB_MEM) ? d_rdata : alu_y;
  assign wb_en   = run_q && (dec.wb != WB_NONE) && (dec.rd != '0);

  // next state
  always_comb begin
    run_d = 1'b1;
    if (!run_q) begin
      pc_d = '0;
    end else if (br_taken) begin
      pc_d = pc_q + dec.imm;
    end else begin
      pc_d = pc_q + XLEN'(4);
    end
    pass_d = pass_q ||
             (wb_en && (dec.rd == RA_W'(PASS_REG)) && (wb_data == XLEN'(PASS_VALUE)));
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pc_q   <= '0;
      pass_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      pc_q   <= pc_d;
      pass_q <= pass_d;
    end
  end

  assign pc_o       = pc_q;
  assign wb_valid_o = wb_en;
  assign wb_rd_o    = dec.rd;
  assign wb_data_o  = wb_data;
  assign pass_o     = pass_q;

endmodule

// File: rtl/mrv_core_chk.sv
module mrv_core_chk #(
  parameter int RA_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            run,
  input logic [31:0]     pc,
  input logic            taken,
  input logic [31:0]     imm,
  input logic            wb_valid,
  input logic [RA_W-1:0] wb_rd,
  input logic            mem_we,
  input logic            pass
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pc == 32'd0 && !wb_valid && !mem_we));

  a_r1_first_fetch_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (pc == 32'd0));

  a_r2_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !taken) |=> (pc == $past(pc) + 32'd4));

  a_r3_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (run && taken) |=> (pc == $past(pc) + $past(imm)));

  a_r6_no_x0_trace: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_rd != '0));

  a_r7_store_no_trace: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wb_valid);

  a_r9_pass_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pass |=> pass);

endmodule

bind mrv_core mrv_core_chk #(.RA_W(RA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (run_q),
  .pc       (pc_q),
  .taken    (br_taken),
  .imm      (dec.imm),
  .wb_valid (wb_valid_o),
  .wb_rd    (wb_rd_o),
  .mem_we   (dmem_we),
  .pass     (pass_o)
);

// File: tb/mrv_core_tb.sv
module mrv_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_we = 1'b0;
  logic [4:0]  imem_waddr = '0;
  logic [31:0] imem_wdata = '0;
  logic [31:0] pc_o;
  logic        wb_valid_o;
  logic [4:0]  wb_rd_o;
  logic [31:0] wb_data_o;
  logic        pass_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] prog [32];

  always #2 clk = ~clk;

  mrv_core u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_we    (imem_we),
    .imem_waddr (imem_waddr),
    .imem_wdata (imem_wdata),
    .pc_o       (pc_o),
    .wb_valid_o (wb_valid_o),
    .wb_rd_o    (wb_rd_o),
    .wb_data_o  (wb_data_o),
    .pass_o     (pass_o)
  );

  // encoders
  function automatic logic [31:0] e_r(input logic [6:0] f7, input int rs2, input int rs1,
                                      input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(input int imm, input int rs1, input logic [2:0] f3,
                                      input int rd, input logic [6:0] opc);
    logic [11:0] v = imm[11:0];
    return {v, 5'(rs1), f3, 5'(rd), opc};
  endfunction
  function automatic logic [31:0] e_s(input int imm, input int rs2, input int rs1);
    logic [11:0] v = imm[11:0];
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(input int imm, input int rs2, input int rs1,
                                      input logic [2:0] f3);
    logic [12:0] v = imm[12:0];
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), f3, v[4:1], v[11], 7'b1100011};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic load_prog();
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      imem_we    = 1'b1;
      imem_waddr = 5'(k);
      imem_wdata = prog[k];
    end
    @(negedge clk);
    imem_we = 1'b0;
  endtask

  // one retired cycle: sample at the falling edge
  task automatic step(input logic [31:0] pc, input bit v, input int rd,
                      input logic [31:0] data, input string req);
    @(negedge clk);
    chk(pc_o == pc, (v || req != "R3") ? "R2" : "R3", "pc", pc_o, pc);
    chk(wb_valid_o == v, req, "wb_valid", 32'(wb_valid_o), 32'(v));
    if (v) begin
      chk(wb_rd_o == 5'(rd), req, "wb_rd", 32'(wb_rd_o), 32'(rd));
      chk(wb_data_o == data, req, "wb_data", wb_data_o, data);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] last10;
    int cyc;

    // ---------- phase 1: sum of 1..9 into x10 ----------
    for (int k = 0; k < 32; k++) prog[k] = e_b(0, 0, 0, 3'b000);
    prog[0] = e_i(0, 0, 3'b000, 10, 7'b0010011);   // x10 = 0
    prog[1] = e_i(1, 0, 3'b000, 2, 7'b0010011);    // x2 = 1
    prog[2] = e_i(10, 0, 3'b000, 3, 7'b0010011);   // x3 = 10
    prog[3] = e_r(7'h00, 2, 10, 3'b000, 10);        // x10 += x2
    prog[4] = e_i(1, 2, 3'b000, 2, 7'b0010011);    // x2 += 1
    prog[5] = e_b(-8, 3, 2, 3'b100);                // blt x2,x3,-8
    prog[6] = e_b(0, 0, 0, 3'b000);                 // halt
    load_prog();
    @(negedge clk);
    chk(pc_o == 0, "R1", "pc in reset", pc_o, 0);
    chk(!wb_valid_o, "R1", "wb in reset", 32'(wb_valid_o), 0);
    chk(!pass_o, "R1", "pass in reset", 32'(pass_o), 0);
    rst_n = 1'b1;
    #1;
    chk(pc_o == 0 && !wb_valid_o, "R1", "first cycle idle", pc_o, 0);
    last10 = '0;
    cyc = 0;
    for (int c = 1; c <= 40; c++) begin
      @(negedge clk);
      cyc = c;
      if (c == 1) chk(pc_o == 0 && wb_valid_o, "R1", "address 0 retires", pc_o, 0);
      if (wb_valid_o && wb_rd_o == 5'd10) last10 = wb_data_o;
      if (pass_o) break;
    end
    chk(pass_o, "R9", "pass within 40 cycles", 32'(cyc), 40);
    chk(last10 == 32'd45, "R9", "x10 sum", last10, 45);
    repeat (3) @(negedge clk);
    chk(pc_o == 32'd24, "R3", "halt pc", pc_o, 24);
    @(negedge clk);
    chk(pc_o == 32'd24, "R3", "halt holds", pc_o, 24);
    chk(pass_o, "R9", "pass sticky", 32'(pass_o), 1);

    // ---------- phase 2: directed instruction mix ----------
    rst_n = 1'b0;
    #1;
    chk(!pass_o, "R9", "pass cleared by reset", 32'(pass_o), 0);
    for (int k = 0; k < 32; k++) prog[k] = e_b(0, 0, 0, 3'b000);
    prog[0]  = e_i(7, 0, 3'b000, 1, 7'b0010011);       // addi x1,x0,7
    prog[1]  = e_i(-3, 0, 3'b000, 2, 7'b0010011);      // addi x2,x0,-3
    prog[2]  = e_r(7'h00, 2, 1, 3'b000, 3);             // add
    prog[3]  = e_r(7'h20, 1, 2, 3'b000, 4);             // sub x4=x2-x1
    prog[4]  = e_r(7'h00, 2, 1, 3'b111, 5);             // and
    prog[5]  = e_r(7'h00, 2, 1, 3'b110, 6);             // or
    prog[6]  = e_r(7'h00, 2, 1, 3'b100, 7);             // xor
    prog[7]  = e_i(-1, 1, 3'b100, 8, 7'b0010011);      // xori
    prog[8]  = e_i(15, 2, 3'b111, 9, 7'b0010011);      // andi
    prog[9]  = e_i(256, 0, 3'b110, 11, 7'b0010011);    // ori
    prog[10] = e_i(5, 1, 3'b000, 0, 7'b0010011);       // addi x0 (ignored)
    prog[11] = e_r(7'h00, 1, 0, 3'b000, 12);            // add x12,x0,x1
    prog[12] = e_s(8, 1, 11);                           // sw x1,8(x11)
    prog[13] = e_s(-4, 2, 11);                          // sw x2,-4(x11)
    prog[14] = e_i(8, 11, 3'b010, 13, 7'b0000011);     // lw x13,8(x11)
    prog[15] = e_i(-4, 11, 3'b010, 14, 7'b0000011);    // lw x14,-4(x11)
    prog[16] = e_i(136, 0, 3'b010, 15, 7'b0000011);    // lw x15,0x88(x0) alias
    prog[17] = e_r(7'h00, 1, 1, 3'b000, 1);             // add x1,x1,x1
    prog[18] = e_b(8, 12, 1, 3'b000);                   // beq not taken
    prog[19] = e_b(8, 12, 1, 3'b001);                   // bne taken
    prog[20] = e_i(99, 0, 3'b000, 17, 7'b0010011);
    prog[21] = e_b(8, 1, 2, 3'b100);                    // blt -3<14 taken
    prog[22] = e_i(98, 0, 3'b000, 17, 7'b0010011);
    prog[23] = e_b(8, 1, 2, 3'b101);                    // bge -3>=14 not taken
    prog[24] = e_b(8, 2, 1, 3'b101);                    // bge 14>=-3 taken
    prog[25] = e_i(97, 0, 3'b000, 17, 7'b0010011);
    prog[26] = e_b(0, 0, 0, 3'b000);                    // halt
    load_prog();
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(pc_o == 0 && !wb_valid_o, "R1", "first cycle idle", pc_o, 0);
    step(0,   1, 1,  32'd7,        "R5");
    step(4,   1, 2,  32'hFFFFFFFD, "R5");
    step(8,   1, 3,  32'd4,        "R4");
    step(12,  1, 4,  32'hFFFFFFF6, "R4");
    step(16,  1, 5,  32'd5,        "R4");
    step(20,  1, 6,  32'hFFFFFFFF, "R4");
    step(24,  1, 7,  32'hFFFFFFFA, "R4");
    step(28,  1, 8,  32'hFFFFFFF8, "R5");
    step(32,  1, 9,  32'h0000000D, "R5");
    step(36,  1, 11, 32'h00000100, "R5");
    step(40,  0, 0,  32'd0,        "R6");
    step(44,  1, 12, 32'd7,        "R6");
    step(48,  0, 0,  32'd0,        "R7");
    step(52,  0, 0,  32'd0,        "R7");
    step(56,  1, 13, 32'd7,        "R7");
    step(60,  1, 14, 32'hFFFFFFFD, "R7");
    step(64,  1, 15, 32'd7,        "R7");
    step(68,  1, 1,  32'd14,       "R8");
    step(72,  0, 0,  32'd0,        "R3");
    step(76,  0, 0,  32'd0,        "R3");
    step(84,  0, 0,  32'd0,        "R3");
    step(92,  0, 0,  32'd0,        "R3");
    step(96,  0, 0,  32'd0,        "R3");
    step(104, 0, 0,  32'd0,        "R3");
    step(104, 0, 0,  32'd0,        "R3");
    chk(!pass_o, "R9", "pass stays low without 45 in x10", 32'(pass_o), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule